// File: doc/BRIEF.md
# Time-Slot Data Link Insert/Extract Gate

This block sits beside the serial bit path of a T1/E1 framer and carves an external data link out of it. For each bit period the framer presents the position of the current bit: the parity of the frame number, the time-slot index, the bit index within the slot, a marker for the T1 framing bit, and a marker for the first bit of a frame. The gate decides whether that bit belongs to the external link. If it does, the transmit bit is taken from an external serial input in place of the internal data, and both directions emit a one-cycle strobe. The received stream is passed through untouched in every bit period. Only the receive strobe picks out the link bits.

Two 8-bit configuration words are written through a small write port. The slot word holds an enable, a two-bit frame-select code and a five-bit slot number. The mask word selects bit positions within that slot. New values are held in a shadow copy and take effect only at the first bit of the next frame.

Top module: `dlink_slot_gate`

## Requirements
- R1: Address 0 writes the slot word, laid out as enable in bit 7, frame-select code in bits 6:5 and slot number in bits 4:0. Address 1 writes the 8-bit bit-position mask.
- R2: While the active enable bit is 0, no bit qualifies: both strobes stay low and tx_out repeats tx_in.
- R3: With e1_mode low, the frame-select codes mean: 00 no frame, 01 frames with frame_odd high, 10 frames with frame_odd low, 11 every frame.
- R4: With e1_mode high, the frame-select codes mean: 00 no frame, 01 frames with frame_odd low, 10 frames with frame_odd high, 11 every frame.
- R5: A bit qualifies only when slot_idx equals the active slot number and mask bit number bit_idx is 1. bit_idx 0 is the first bit sent in the slot, which is the octet MSB.
- R6: On every cycle with bit_en high, rx_out takes rx_in on that edge. rx_strobe is high in the following cycle exactly when the bit qualified.
- R7: On a qualified bit, tx_out takes ext_tx_in and tx_strobe pulses. On any other bit, tx_out takes tx_in.
- R8: In T1 mode, a bit with t1_fbit high never qualifies, whatever the slot and mask settings.
- R9: A strobe is high for one cycle only, directly after a cycle with bit_en high. It is low in every other cycle.
- R10: A configuration write takes effect on the first bit-period with frame_start high that follows the write. That bit is already gated under the new settings, and the frame in progress keeps the old ones.
- R11: After reset, all outputs are 0 and both configuration words, shadow and active, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = slot word, 1 = bit mask |
| cfg_wdata | input | 8 | Configuration write data |
| e1_mode | input | 1 | 1 = E1 numbering, 0 = T1 numbering |
| bit_en | input | 1 | One bit period is presented this cycle |
| frame_start | input | 1 | The presented bit is the first bit of a frame |
| frame_odd | input | 1 | LSB of the framer's frame number |
| t1_fbit | input | 1 | The presented bit is the T1 framing bit |
| slot_idx | input | 5 | Time-slot index of the presented bit |
| bit_idx | input | 3 | Bit index in slot, 0 = first sent |
| tx_in | input | 1 | Internal transmit bit |
| ext_tx_in | input | 1 | External serial data for link bits |
| rx_in | input | 1 | Received bit |
| tx_out | output | 1 | Transmit bit after insertion |
| tx_strobe | output | 1 | Marks a transmit bit taken from ext_tx_in |
| rx_out | output | 1 | Received bit, passed through |
| rx_strobe | output | 1 | Marks a received link bit |

## Verification
A wrong active configuration or a wrong parity decode shows up as a strobe count per frame that differs from the count the settings imply. It also shows as a tx_out bit that follows the wrong source, and it appears one cycle after the affected bit period. A shadow word that loads too early or too late shows up within a frame: strobes move in the middle of the frame where the write happened, or the first frame after the write stays on the old slot. A wrong framing-bit gate shows up as an extra strobe on the first bit of a T1 frame.

// File: rtl/dlink_pkg.sv
package dlink_pkg;

    localparam int REG_W    = 8;
    localparam int SLOT_W   = 5;
    localparam int BITIX_W  = 3;
    localparam int MASK_W   = 1 << BITIX_W;

    localparam logic ADDR_SLOT = 1'b0;
    localparam logic ADDR_MASK = 1'b1;

    typedef enum logic [1:0] {
        FS_NONE   = 2'b00,
        FS_CODE_A = 2'b01,
        FS_CODE_B = 2'b10,
        FS_ALL    = 2'b11
    } fsel_e;

    typedef struct packed {
        logic              en;
        fsel_e             fsel;
        logic [SLOT_W-1:0] slot;
    } slot_cfg_t;

    // Frame parity decode. T1 counts frames from 1 and E1 from 0, so code A
    // selects the odd LSB in T1 and the even LSB in E1 (code B the reverse).
    function automatic logic frame_pick(fsel_e f, logic e1, logic odd);
        logic r;
        case (f)
            FS_NONE:   r = 1'b0;
            FS_CODE_A: r = e1 ? ~odd : odd;
            FS_CODE_B: r = e1 ? odd : ~odd;
            default:   r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dlink_cfg_regs.sv
module dlink_cfg_regs
    import dlink_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic                 addr,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 load,
    output slot_cfg_t            eff_cfg,
    output logic [MASK_W-1:0]    eff_mask
);

    slot_cfg_t          shd_cfg, act_cfg;
    logic [MASK_W-1:0]  shd_mask, act_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_cfg  <= '0;
            shd_mask <= '0;
        end else if (we) begin
            if (addr == ADDR_SLOT) shd_cfg  <= slot_cfg_t'(wdata);
            else                   shd_mask <= wdata[MASK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg  <= '0;
            act_mask <= '0;
        end else if (load) begin
            act_cfg  <= shd_cfg;
            act_mask <= shd_mask;
        end
    end

    // The first bit of a frame already sees the new settings.
    always_comb begin
        eff_cfg  = load ? shd_cfg  : act_cfg;
        eff_mask = load ? shd_mask : act_mask;
    end

    a_r10_hold_midframe: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(act_cfg) && $stable(act_mask)));

    a_r1_slot_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == ADDR_SLOT) |=> shd_cfg == $past(wdata));

endmodule

// File: rtl/dlink_qualifier.sv
module dlink_qualifier
    import dlink_pkg::*;
(
    input  slot_cfg_t           cfg,
    input  logic [MASK_W-1:0]   mask,
    input  logic                e1_mode,
    input  logic                frame_odd,
    input  logic                t1_fbit,
    input  logic [SLOT_W-1:0]   slot_idx,
    input  logic [BITIX_W-1:0]  bit_idx,
    output logic                qual
);

    logic frame_ok, slot_ok, bit_ok, fbit_block;

    always_comb begin
        frame_ok   = frame_pick(cfg.fsel, e1_mode, frame_odd);
        slot_ok    = (slot_idx == cfg.slot);
        bit_ok     = mask[bit_idx];
        fbit_block = ~e1_mode & t1_fbit;
        qual       = cfg.en & frame_ok & slot_ok & bit_ok & ~fbit_block;
    end

endmodule

// File: rtl/dlink_lane.sv
module dlink_lane (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic qual,
    input  logic tx_in,
    input  logic ext_tx_in,
    input  logic rx_in,
    output logic tx_out,
    output logic tx_strobe,
    output logic rx_out,
    output logic rx_strobe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_out    <= 1'b0;
            rx_out    <= 1'b0;
            tx_strobe <= 1'b0;
            rx_strobe <= 1'b0;
        end else begin
            tx_strobe <= bit_en & qual;
            rx_strobe <= bit_en & qual;
            if (bit_en) begin
                tx_out <= qual ? ext_tx_in : tx_in;
                rx_out <= rx_in;
            end
        end
    end

    a_r6_rx_pass: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> rx_out == $past(rx_in));

    a_r7_tx_insert: assert property (@(posedge clk) disable iff (rst)
        (bit_en && qual) |=> (tx_out == $past(ext_tx_in) && tx_strobe));

    a_r9_strobe_after_bit: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> (!tx_strobe && !rx_strobe));

endmodule

// File: rtl/dlink_slot_gate.sv
module dlink_slot_gate
    import dlink_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic                cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    input  logic                e1_mode,
    input  logic                bit_en,
    input  logic                frame_start,
    input  logic                frame_odd,
    input  logic                t1_fbit,
    input  logic [SLOT_W-1:0]   slot_idx,
    input  logic [BITIX_W-1:0]  bit_idx,
    input  logic                tx_in,
    input  logic                ext_tx_in,
    input  logic                rx_in,
    output logic                tx_out,
    output logic                tx_strobe,
    output logic                rx_out,
    output logic                rx_strobe
);

    slot_cfg_t          eff_cfg;
    logic [MASK_W-1:0]  eff_mask;
    logic               qual;
    logic               load;

    assign load = bit_en & frame_start;

    dlink_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .load     (load),
        .eff_cfg  (eff_cfg),
        .eff_mask (eff_mask)
    );

    dlink_qualifier u_qual (
        .cfg       (eff_cfg),
        .mask      (eff_mask),
        .e1_mode   (e1_mode),
        .frame_odd (frame_odd),
        .t1_fbit   (t1_fbit),
        .slot_idx  (slot_idx),
        .bit_idx   (bit_idx),
        .qual      (qual)
    );

    dlink_lane u_lane (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .qual      (qual),
        .tx_in     (tx_in),
        .ext_tx_in (ext_tx_in),
        .rx_in     (rx_in),
        .tx_out    (tx_out),
        .tx_strobe (tx_strobe),
        .rx_out    (rx_out),
        .rx_strobe (rx_strobe)
    );

    a_r8_fbit_never: assert property (@(posedge clk) disable iff (rst)
        (bit_en && t1_fbit && !e1_mode) |=> (!tx_strobe && tx_out == $past(tx_in)));

    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !eff_cfg.en) |=> (!tx_strobe && !rx_strobe));

    a_r9_strobes_agree: assert property (@(posedge clk) disable iff (rst)
        tx_strobe == rx_strobe);

endmodule

// File: tb/test_dlink_slot_gate.sv
module test_dlink_slot_gate;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we, cfg_addr;
    logic [7:0] cfg_wdata;
    logic       e1_mode, bit_en, frame_start, frame_odd, t1_fbit;
    logic [4:0] slot_idx;
    logic [2:0] bit_idx;
    logic       tx_in, ext_tx_in, rx_in;
    logic       tx_out, tx_strobe, rx_out, rx_strobe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] pend_slot = 8'h00, pend_mask = 8'h00;
    logic [7:0] act_slot  = 8'h00, act_mask  = 8'h00;

    always #10 clk = ~clk;

    dlink_slot_gate i_dlink_slot_gate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .e1_mode(e1_mode), .bit_en(bit_en),
        .frame_start(frame_start), .frame_odd(frame_odd), .t1_fbit(t1_fbit),
        .slot_idx(slot_idx), .bit_idx(bit_idx), .tx_in(tx_in),
        .ext_tx_in(ext_tx_in), .rx_in(rx_in), .tx_out(tx_out),
        .tx_strobe(tx_strobe), .rx_out(rx_out), .rx_strobe(rx_strobe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of qualification taken from R2..R5, R8.
    function automatic bit model_q(bit e1, bit fb, int frame, int slot, int bidx);
        bit odd = frame[0];
        bit fok;
        if (!act_slot[7]) return 0;
        if (!e1 && fb) return 0;
        case (act_slot[6:5])
            2'b00: fok = 0;
            2'b01: fok = e1 ? !odd : odd;
            2'b10: fok = e1 ? odd : !odd;
            default: fok = 1;
        endcase
        return fok && (slot == int'(act_slot[4:0])) && act_mask[bidx];
    endfunction

    task automatic wr(input bit a, input logic [7:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        if (a) pend_mask = d; else pend_slot = d;
    endtask

    task automatic send_bit(input string req, input bit e1, input bit fs, input bit fb,
                            input int frame, input int slot, input int bidx,
                            inout int nstb);
        bit q, td, xd, rd;
        int exp_tx;
        td = (slot[0] ^ bidx[1] ^ frame[1]);
        xd = ~(slot[1] ^ bidx[0]);
        rd = (slot[2] ^ bidx[2] ^ bidx[0]);
        if (fs) begin act_slot = pend_slot; act_mask = pend_mask; end
        q = model_q(e1, fb, frame, slot, bidx);
        e1_mode = e1; frame_start = fs; t1_fbit = fb; frame_odd = frame[0];
        slot_idx = 5'(slot); bit_idx = 3'(bidx);
        tx_in = td; ext_tx_in = xd; rx_in = rd; bit_en = 1;
        @(negedge clk);
        bit_en = 0; frame_start = 0; t1_fbit = 0;
        exp_tx = q ? xd : td;
        // R6 R7 per bit: {tx_out, tx_strobe, rx_out, rx_strobe}
        check(req, {tx_out, tx_strobe, rx_out, rx_strobe}, {exp_tx[0], q, rd, q});
        if (tx_strobe) nstb++;
        @(negedge clk);
        check("R9 strobe low in gap", {tx_strobe, rx_strobe}, 0);
    endtask

    task automatic run_frame(input string req, input bit e1, input int frame,
                             input bit do_wr, input bit wa, input logic [7:0] wd,
                             output int nstb);
        int ns = 0;
        int nslots = e1 ? 32 : 24;
        if (!e1) send_bit(req, 0, 1, 1, frame, 0, 0, ns);
        for (int s = 0; s < nslots; s++) begin
            if (do_wr && s == 3) wr(wa, wd);
            for (int b = 0; b < 8; b++)
                send_bit(req, e1, (e1 && s == 0 && b == 0), 0, frame, s, b, ns);
        end
        nstb = ns;
    endtask

    task automatic t_reset();
        check("R11 reset outputs", {tx_out, tx_strobe, rx_out, rx_strobe}, 0);
    endtask

    task automatic t_t1_all();
        int n;
        wr(0, 8'hE5); wr(1, 8'hFF);
        run_frame("R5 R1 T1 all slot5", 0, 1, 0, 0, 0, n); check("R3 T1 all f1 count", n, 8);
        run_frame("R5 T1 all slot5", 0, 2, 0, 0, 0, n); check("R3 T1 all f2 count", n, 8);
    endtask

    task automatic t_t1_odd_even();
        int n;
        wr(0, 8'hA5); wr(1, 8'h81);
        run_frame("R3 T1 odd", 0, 1, 0, 0, 0, n); check("R3 T1 odd f1", n, 2);
        run_frame("R3 T1 odd", 0, 2, 0, 0, 0, n); check("R3 T1 odd f2", n, 0);
        wr(0, 8'hC5);
        run_frame("R3 T1 even", 0, 3, 0, 0, 0, n); check("R3 T1 even f3", n, 0);
        run_frame("R3 T1 even", 0, 4, 0, 0, 0, n); check("R3 T1 even f4", n, 2);
    endtask

    task automatic t_e1_codes();
        int n;
        wr(0, 8'hA0); wr(1, 8'h01);
        run_frame("R4 E1 code01", 1, 0, 0, 0, 0, n); check("R4 E1 code01 f0", n, 1);
        run_frame("R4 E1 code01", 1, 1, 0, 0, 0, n); check("R4 E1 code01 f1", n, 0);
        wr(0, 8'hC0);
        run_frame("R4 E1 code10", 1, 2, 0, 0, 0, n); check("R4 E1 code10 f2", n, 0);
        run_frame("R4 E1 code10", 1, 3, 0, 0, 0, n); check("R4 E1 code10 f3", n, 1);
        wr(0, 8'hFF); wr(1, 8'h80);
        run_frame("R5 E1 slot31 last bit", 1, 4, 0, 0, 0, n); check("R5 E1 slot31 count", n, 1);
    endtask

    task automatic t_disabled();
        int n;
        wr(0, 8'h65); wr(1, 8'hFF);
        run_frame("R2 disabled", 0, 1, 0, 0, 0, n); check("R2 disabled count", n, 0);
        wr(0, 8'h85);
        run_frame("R3 code00", 0, 2, 0, 0, 0, n); check("R3 code00 count", n, 0);
    endtask

    task automatic t_fbit();
        int n;
        wr(0, 8'hE0); wr(1, 8'h01);
        run_frame("R8 T1 fbit", 0, 1, 0, 0, 0, n); check("R8 slot0 only, no fbit", n, 1);
    endtask

    task automatic t_midframe();
        int n;
        wr(0, 8'hE5); wr(1, 8'hFF);
        run_frame("R10 midframe write", 0, 1, 1, 1, 8'h0F, n); check("R10 old mask kept", n, 8);
        run_frame("R10 new mask", 0, 2, 0, 0, 0, n); check("R10 new mask applied", n, 4);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; e1_mode = 0;
        bit_en = 0; frame_start = 0; frame_odd = 0; t1_fbit = 0;
        slot_idx = 0; bit_idx = 0; tx_in = 0; ext_tx_in = 0; rx_in = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_t1_all();
        t_t1_odd_even();
        t_e1_codes();
        t_disabled();
        t_fbit();
        t_midframe();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule